// File: doc/BRIEF.md
# Banked Indirect Register Window

This block is a slave-side register file. Three directly addressed registers give a host access to a much larger space of banked extended registers. The host talks to it over a simple synchronous register bus with an address, write data, a write enable, a read enable and registered read data. The block stands behind a management serial link, which lies outside it.

An extended access takes one command word, written to the command register. The word holds a 3-bit bank number, an 8-bit offset and two direction bits.

- For a write, the host first stages the data word in the write-staging register. It then writes the command, and the staged word is copied into the selected entry.
- For a read, the host writes the command. The entry's value is then latched into the read-result register, which the host fetches with an ordinary bus read.
- Bank 0 is an alias of the directly addressed registers themselves. Banks 1 to 3 are internal storage. Banks 4 to 7 hold nothing.

Top module: `ext_reg_window`

## Requirements
- R1: The direct map has the command register at address 0x14, the read-result register at 0x15 and the write-staging register at 0x16. Every other direct address (0x00 to 0x1F) is a plain 16-bit read/write register. A bus read with `bus_re` high places the addressed value on `bus_rdata` after that clock edge, and `bus_rdata` holds when `bus_re` is low.
- R2: In the command word, bit 12 requests a read, bit 11 requests a write, bits 10:8 give the bank and bits 7:0 give the offset. Reading the command register back returns the last bank and offset in bits 10:0, with bits 15:11 at zero.
- R3: A command write with only bit 11 set copies the write-staging register into the addressed entry at that clock edge.
- R4: A command write with only bit 12 set loads the addressed entry's value into the read-result register at that clock edge, so the next bus read of 0x15 returns it.
- R5: Banks 1, 2 and 3 each hold BANK_DEPTH entries (64 by default). At an offset at or above the depth, a read yields 0x0000 and a write is dropped.
- R6: Bank 0 aliases the direct registers.
  - An extended read of offset 0x00 to 0x1F returns the same value a direct read of that address would give at that moment.
  - An extended write updates the plain direct register at that address.
  - Extended writes to offsets 0x14, 0x15, 0x16 or to offsets 0x20 and above are dropped.
  - Extended reads at offsets 0x20 and above yield 0x0000.
- R7: Banks 4 to 7 are unimplemented: reads yield 0x0000 and writes are dropped.
- R8: A command word with both bits 12 and 11 set, or with neither, performs no transfer. The read-result register and all entries are unchanged, but the bank and offset are still recorded.
- R9: After a synchronous active-low reset, every direct register and every bank entry reads 0x0000.
- R10: A direct bus write to 0x15 is ignored; the read-result register changes only through a read command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Direct register address |
| bus_wdata | input | 16 | Bus write data |
| bus_we | input | 1 | Bus write enable |
| bus_re | input | 1 | Bus read enable |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions take for granted that the host never raises `bus_we` and `bus_re` in the same cycle. They also assume every command is a single-cycle write, so at most one transfer is in flight. The stimulus issues exactly one bus operation per task call, with the enables dropped between operations. Random commands draw banks from the whole 0 to 7 range and offsets from the whole 8-bit range. The direction bits are drawn across all four combinations, so the out-of-range, unimplemented-bank and no-transfer paths are all reached.

// File: rtl/ewin_pkg.sv
// Package: shared constants and types for the banked register window.
// Assumes a 16-bit data path and a direct space of at least 32 addresses.
package ewin_pkg;
    localparam int CMD_RD_BIT = 12;
    localparam int CMD_WR_BIT = 11;
    localparam int BANK_W     = 3;
    localparam int OFF_W      = 8;
    localparam int CTL_W      = BANK_W + OFF_W;
    localparam logic [4:0] ADDR_CMD = 5'h14;
    localparam logic [4:0] ADDR_RES = 5'h15;
    localparam logic [4:0] ADDR_STG = 5'h16;

    // Decoded form of one command word
    typedef struct packed {
        logic              do_read;
        logic              do_write;
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  offset;
    } ewin_cmd_t;

    // True when a direct address is one of the three window registers
    function automatic logic is_window_addr(input logic [4:0] a);
        return (a == ADDR_CMD) || (a == ADDR_RES) || (a == ADDR_STG);
    endfunction
endpackage

// File: rtl/ewin_cmd_decode.sv
// Module: splits a command word into direction, bank and offset.
// Assumes the caller only acts on the result when the command register is written.
// A word with both or neither direction bits yields no transfer.
module ewin_cmd_decode
    import ewin_pkg::*;
(
    input  logic [CMD_RD_BIT:0] word,
    output ewin_cmd_t           cmd
);
    // Decode direction exclusively and pass bank and offset through
    always_comb begin
        cmd.do_read  = word[CMD_RD_BIT] & ~word[CMD_WR_BIT];
        cmd.do_write = word[CMD_WR_BIT] & ~word[CMD_RD_BIT];
        cmd.bank     = word[CMD_WR_BIT-1:OFF_W];
        cmd.offset   = word[OFF_W-1:0];
    end
endmodule

// File: rtl/ewin_bank_store.sv
// Module: one bank of extended registers with a single write port and a
// combinational read port. Offsets at or above DEPTH read zero and writes
// to them are dropped. All entries clear on reset.
module ewin_bank_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int OW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [OW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [OW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic          w_in_range;
    logic          r_in_range;

    // Range checks on both ports
    always_comb begin
        w_in_range = (32'(waddr) < DEPTH);
        r_in_range = (32'(raddr) < DEPTH);
    end

    // Storage update: reset clears, in-range writes land
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && w_in_range) begin
            mem[waddr[IW-1:0]] <= wdata;
        end
    end

    // Read port: zero outside the implemented range
    always_comb begin
        rdata = r_in_range ? mem[raddr[IW-1:0]] : '0;
    end
endmodule

// File: rtl/ewin_direct_regs.sv
// Module: the directly addressed register space. Holds the command fields,
// the read-result and write-staging registers and plain registers at all
// other addresses. Port A serves the bus; port B serves the bank 0 alias.
// Assumes the bus write and the alias write never target the same plain
// register in one cycle (the alias write only happens on a command write).
module ewin_direct_regs
    import ewin_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          alias_we,
    input  logic [AW-1:0] alias_addr,
    input  logic [DW-1:0] alias_wdata,
    input  logic          res_load,
    input  logic [DW-1:0] res_value,
    output logic [DW-1:0] stage_q,
    output logic [DW-1:0] result_q,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    localparam int NREG = 1 << AW;

    logic [CTL_W-1:0] ctl_q;
    logic [DW-1:0]    view [NREG];

    // Command register: keep bank and offset of every command write
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ctl_q <= '0;
        else if (bus_we && bus_addr == AW'(ADDR_CMD)) ctl_q <= bus_wdata[CTL_W-1:0];
    end

    // Write-staging register: loaded by direct bus writes only
    always_ff @(posedge clk) begin
        if (!rst_n)                                   stage_q <= '0;
        else if (bus_we && bus_addr == AW'(ADDR_STG)) stage_q <= bus_wdata;
    end

    // Read-result register: loaded only by a read command
    always_ff @(posedge clk) begin
        if (!rst_n)        result_q <= '0;
        else if (res_load) result_q <= res_value;
    end

    // One plain register per non-window address, window views elsewhere
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == int'(ADDR_CMD)) begin : g_cmd
            assign view[g] = {{(DW-CTL_W){1'b0}}, ctl_q};
        end else if (g == int'(ADDR_RES)) begin : g_res
            assign view[g] = result_q;
        end else if (g == int'(ADDR_STG)) begin : g_stg
            assign view[g] = stage_q;
        end else begin : g_plain
            logic [DW-1:0] q;
            // Plain register: bus write first, alias write otherwise
            always_ff @(posedge clk) begin
                if (!rst_n)                                 q <= '0;
                else if (bus_we && bus_addr == AW'(g))      q <= bus_wdata;
                else if (alias_we && alias_addr == AW'(g))  q <= alias_wdata;
            end
            assign view[g] = q;
        end
    end

    // Two combinational read ports over the same view
    always_comb begin
        rd_a = view[bus_addr];
        rd_b = view[alias_addr];
    end
endmodule

// File: rtl/ext_reg_window.sv
// Module: top of the banked indirect register window. A write to the command
// register decodes direction, bank and offset and moves one word between the
// staging/result registers and the addressed entry in that same clock edge.
// Bank 0 aliases the direct space, banks 1..NUM_EXT are storage, the rest
// are empty. Bus reads are registered and hold when not enabled.
// Assumes bus_we and bus_re are never high together.
module ext_reg_window
    import ewin_pkg::*;
#(
    parameter int DW         = 16,
    parameter int AW         = 5,
    parameter int BANK_DEPTH = 64,
    parameter int NUM_EXT    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [15:0]   bus_rdata
);
    localparam int HI_W = OFF_W - AW;

    ewin_cmd_t     cmd;
    logic          cmd_hit;
    logic          alias_in_range;
    logic          alias_we;
    logic [DW-1:0] stage_q;
    logic [DW-1:0] result_q;
    logic [DW-1:0] rd_a;
    logic [DW-1:0] rd_b;
    logic [DW-1:0] ext_val;
    logic [DW-1:0] bank_rd [1:NUM_EXT];
    logic          bank_we [1:NUM_EXT];

    ewin_cmd_decode u_dec (
        .word (bus_wdata[CMD_RD_BIT:0]),
        .cmd  (cmd)
    );

    // Command strobe and bank 0 alias qualification
    always_comb begin
        cmd_hit        = bus_we && (bus_addr == ADDR_CMD);
        alias_in_range = (cmd.offset[OFF_W-1:AW] == HI_W'(0));
        alias_we       = cmd_hit && cmd.do_write && (cmd.bank == '0)
                         && alias_in_range;
    end

    ewin_direct_regs #(.DW(DW), .AW(AW)) u_dir (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .alias_we    (alias_we),
        .alias_addr  (cmd.offset[AW-1:0]),
        .alias_wdata (stage_q),
        .res_load    (cmd_hit && cmd.do_read),
        .res_value   (ext_val),
        .stage_q     (stage_q),
        .result_q    (result_q),
        .rd_a        (rd_a),
        .rd_b        (rd_b)
    );

    // Storage banks 1..NUM_EXT
    for (genvar b = 1; b <= NUM_EXT; b++) begin : g_bank
        assign bank_we[b] = cmd_hit && cmd.do_write && (cmd.bank == BANK_W'(b));
        ewin_bank_store #(.DW(DW), .DEPTH(BANK_DEPTH), .OW(OFF_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .waddr (cmd.offset),
            .wdata (stage_q),
            .raddr (cmd.offset),
            .rdata (bank_rd[b])
        );
    end

    // Extended read mux: alias, storage bank, or zero
    always_comb begin
        ext_val = '0;
        if (cmd.bank == '0) begin
            if (alias_in_range) ext_val = rd_b;
        end else begin
            for (int i = 1; i <= NUM_EXT; i++)
                if (cmd.bank == BANK_W'(i)) ext_val = bank_rd[i];
        end
    end

    // Registered bus read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_a;
    end
endmodule

// File: rtl/ewin_checker.sv
// Checker: temporal properties of the register window, bound to the top.
// Assumes one bus operation per cycle.
module ewin_checker #(
    parameter int BANK_DEPTH = 64,
    parameter int NUM_EXT    = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        bus_we,
    input logic        bus_re,
    input logic [15:0] bus_rdata,
    input logic [15:0] result_q
);
    logic rd_cmd;
    logic [2:0] bnk;
    logic [7:0] off;

    // Recognise a read-only command write from the ports
    always_comb begin
        rd_cmd = bus_we && bus_addr == 5'h14 && bus_wdata[12] && !bus_wdata[11];
        bnk    = bus_wdata[10:8];
        off    = bus_wdata[7:0];
    end

    a_r1_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    a_r2_cmd_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 5'h14) |=> (bus_rdata[15:11] == 5'b0));

    a_r8_no_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cmd |=> $stable(result_q));

    a_r10_direct_result_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 5'h15) |=> $stable(result_q));

    a_r5_beyond_depth_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && bnk != 3'd0 && 32'(bnk) <= NUM_EXT && 32'(off) >= BANK_DEPTH)
        |=> (result_q == 16'h0000));

    a_r7_empty_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && 32'(bnk) > NUM_EXT) |=> (result_q == 16'h0000));
endmodule

bind ext_reg_window ewin_checker #(.BANK_DEPTH(BANK_DEPTH), .NUM_EXT(NUM_EXT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .result_q  (u_dir.result_q)
);

// File: tb/ext_reg_window_test.sv
module ext_reg_window_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_dir [32];
    logic [15:0] m_bank [1:3][DEPTH];
    logic [10:0] m_ctl;
    logic [15:0] m_res;
    logic [15:0] m_stg;

    ext_reg_window uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] dir_read(input logic [4:0] a);
        if (a == 5'h14) return {5'b0, m_ctl};
        if (a == 5'h15) return m_res;
        if (a == 5'h16) return m_stg;
        return m_dir[a];
    endfunction

    function automatic logic [15:0] ext_read(input logic [2:0] b, input logic [7:0] o);
        if (b == 3'd0) return (o < 8'd32) ? dir_read(o[4:0]) : 16'h0;
        if (b <= 3'd3) return (o < 8'(DEPTH)) ? m_bank[b][o[5:0]] : 16'h0;
        return 16'h0;
    endfunction

    // Model of one direct write, including command execution
    task automatic model_write(input logic [4:0] a, input logic [15:0] d);
        logic [2:0] b; logic [7:0] o;
        b = d[10:8]; o = d[7:0];
        if (a == 5'h14) begin
            if (d[12] && !d[11]) m_res = ext_read(b, o);
            if (d[11] && !d[12]) begin
                if (b == 3'd0 && o < 8'd32 && !(o >= 8'h14 && o <= 8'h16))
                    m_dir[o[4:0]] = m_stg;
                else if (b >= 3'd1 && b <= 3'd3 && o < 8'(DEPTH))
                    m_bank[b][o[5:0]] = m_stg;
            end
            m_ctl = d[10:0];
        end else if (a == 5'h16) m_stg = d;
        else if (a != 5'h15) m_dir[a] = d;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_read(input logic [4:0] a, input string tag);
        logic [15:0] exp;
        exp = dir_read(a);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic ext_wr(input logic [2:0] b, input logic [7:0] o, input logic [15:0] d);
        bus_write(5'h16, d);
        bus_write(5'h14, {3'b000, 2'b01, b, o});
    endtask

    task automatic ext_rd(input logic [2:0] b, input logic [7:0] o, input string tag);
        bus_write(5'h14, {3'b000, 2'b10, b, o});
        check_read(5'h15, tag);
    endtask

    initial begin
        int unused_seed;
        for (int i = 0; i < 32; i++) m_dir[i] = '0;
        for (int b = 1; b <= 3; b++)
            for (int i = 0; i < DEPTH; i++) m_bank[b][i] = '0;
        m_ctl = '0; m_res = '0; m_stg = '0;
        unused_seed = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check_read(5'h14, "R9"); check_read(5'h15, "R9");
        check_read(5'h16, "R9"); check_read(5'h03, "R9");
        ext_rd(3'd2, 8'd10, "R9");
        // R1: plain direct register
        bus_write(5'h07, 16'hA5C3); check_read(5'h07, "R1");
        // R3/R4: write then read back through bank 1 and 3
        ext_wr(3'd1, 8'd5, 16'h1234); ext_rd(3'd1, 8'd5, "R3");
        ext_wr(3'd3, 8'd63, 16'hBEEF); ext_rd(3'd3, 8'd63, "R4");
        // R2: command readback with command bits cleared
        bus_write(5'h14, 16'hFABC); check_read(5'h14, "R2");
        // R5: beyond depth
        ext_wr(3'd2, 8'd64, 16'h7777); ext_rd(3'd2, 8'd64, "R5");
        ext_rd(3'd2, 8'd0, "R5");
        // R7: unimplemented bank
        ext_wr(3'd5, 8'd1, 16'h5555); ext_rd(3'd5, 8'd1, "R7");
        // R8: both and neither bits
        ext_rd(3'd1, 8'd5, "R8");
        bus_write(5'h16, 16'h9999);
        bus_write(5'h14, {3'b000, 2'b11, 3'd1, 8'd5}); check_read(5'h15, "R8");
        bus_write(5'h14, {3'b000, 2'b00, 3'd1, 8'd5}); check_read(5'h14, "R8");
        ext_rd(3'd1, 8'd5, "R8");
        // R6: bank 0 alias
        ext_wr(3'd0, 8'd3, 16'h0F0F); check_read(5'h03, "R6");
        ext_rd(3'd0, 8'h16, "R6");
        ext_wr(3'd0, 8'h16, 16'h4321); check_read(5'h16, "R6");
        ext_rd(3'd0, 8'h40, "R6");
        // R10: direct write to result register ignored
        bus_write(5'h15, 16'hDEAD); check_read(5'h15, "R10");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [2:0] b; logic [7:0] o;
            kind = $urandom_range(0, 4);
            b = 3'($urandom_range(0, 7));
            o = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 70)) : 8'($urandom);
            case (kind)
                0: bus_write(5'($urandom), 16'($urandom));
                1: check_read(5'($urandom), "R1");
                2: ext_wr(b, o, 16'($urandom));
                3: ext_rd(b, o, "R4");
                default: begin
                    bus_write(5'h14, {3'($urandom), 2'($urandom), b, o});
                    check_read(5'h15, "R8");
                end
            endcase
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule